// File: doc/BRIEF.md
# Gated Card Bus Clock Generator

This block derives the serial clock of a card bus from the system clock. Command, response and data bits on the bus all shift on this one clock. The block holds the bus clock low after reset and keeps it low until software sets the enable input. Once enabled, it divides the system clock by a programmable base factor. It also produces a one-cycle strobe on every rising edge of the bus clock, which the shift logic uses to advance.

Two further controls shape the clock. A power-save option stretches each half period by a factor of 2^(N+1) while the bus has nothing to do. This factor is removed as soon as a transfer starts. Two protect options, one for reads and one for writes, hold the clock low while the data buffer cannot take or give another bit. This trades throughput for data integrity.

The clock only stops, restarts or changes speed while it is low, so a high pulse is never cut short. The divider and power-save factor are expected to change only while the block is disabled and the clock is low.

Top module: `cclk_gen`

## Requirements
- R1: After reset `card_clk` and `rise_stb` are 0, and `card_clk` stays 0 for as long as `en` is 0.
- R2: With `en`=1, `psave_en`=0 and no stall, `card_clk` has a period of 2*(`div`+1) system clocks and is high for exactly `div`+1 of them.
- R3: `rise_stb` is 1 for exactly the one cycle in which `card_clk` first reads 1 after being 0, and is 0 in every other cycle.
- R4: With `psave_en`=1 and `bus_busy`=0, each half period lasts (`div`+1)*2^(`psave_n`+1) system clocks.
- R5: A high phase keeps the length chosen at its rising edge even if `bus_busy` changes during it. A low phase uses the current `bus_busy`, so a transfer that starts removes the power-save stretch from the next low phase onward.
- R6: When `rd_guard`=1, `rd_active`=1 and `fifo_full`=1, `card_clk` does not rise. Once the condition clears with the low phase already complete, it rises on the next clock edge.
- R7: When `wr_guard`=1, `wr_active`=1 and `fifo_empty`=1, `card_clk` does not rise. Once the condition clears with the low phase already complete, it rises on the next clock edge.
- R8: With `rd_guard`=0 and `wr_guard`=0, the FIFO flags have no effect on `card_clk`.
- R9: Clearing `en` during a high phase lets that phase run to its full length, after which `card_clk` stays 0. On re-enable the low-phase count starts from zero, so the first rise comes `div`+1 cycles after `en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable |
| div | input | DIV_W | Base divider value D |
| psave_en | input | 1 | Power-save enable |
| psave_n | input | PSN_W | Power-save exponent N |
| rd_guard | input | 1 | Stall reads on a full buffer |
| wr_guard | input | 1 | Stall writes on an empty buffer |
| bus_busy | input | 1 | A command or data transfer is in progress |
| rd_active | input | 1 | A read transfer is in progress |
| wr_active | input | 1 | A write transfer is in progress |
| fifo_full | input | 1 | Data buffer cannot accept more |
| fifo_empty | input | 1 | Data buffer has nothing to send |
| card_clk | output | 1 | Bus clock |
| rise_stb | output | 1 | One-cycle strobe on each bus clock rise |

## Verification
Period measurements over several base dividers separate a correct divide-by-2(D+1) from off-by-one counting. Repeating the measurement with power save on and the bus idle exposes a wrong exponent or a stretch applied in the wrong place.

A directed run drops `bus_busy` into a stretched high phase. It tells apart a design that keeps the high length latched from one that changes speed mid-pulse.

Held read and write stalls, and the same FIFO flags with both guards off, separate correct stall gating from gating that ignores a guard or a direction. Enable toggled mid-pulse checks that the high phase completes and that the counters restart from zero.

A long seeded random mix of all inputs is compared cycle by cycle against a reference model in the bench.

// File: rtl/cclk_pkg.sv
// Package: shared types and width helpers for the card clock generator.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package cclk_pkg;

    // Default field widths used by the top module.
    localparam int unsigned CCLK_DIV_W = 8;
    localparam int unsigned CCLK_PSN_W = 3;

    // Number of transfer directions that can request a stall.
    localparam int unsigned CCLK_NDIR = 2;

    // Counter width able to hold (2^dw) << (2^pw) half-period cycles.
    function automatic int unsigned cnt_width(input int unsigned dw, input int unsigned pw);
        return dw + (1 << pw) + 1;
    endfunction

    // One stall source: a guard option, its transfer flag and its buffer flag.
    typedef struct packed {
        logic guard;
        logic active;
        logic blocked;
    } stall_src_t;

    // Phase of the generated clock.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/cclk_stall_ctrl.sv
// Module: decides whether the bus clock may rise in this cycle.
// It combines the enable with every guarded stall source.
// Assumes: the source flags are synchronous to clk.
module cclk_stall_ctrl
    import cclk_pkg::*;
#(
    parameter int unsigned NDIR = CCLK_NDIR
) (
    input  logic       en,
    input  stall_src_t src [NDIR],
    output logic       rise_ok
);

    logic [NDIR-1:0] hold;

    // One hold term per direction: a guarded transfer with its buffer blocked.
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        assign hold[g] = src[g].guard & src[g].active & src[g].blocked;
    end

    // A rise is allowed only when enabled and no direction holds the clock.
    always_comb begin
        rise_ok = en & ~(|hold);
    end

endmodule

// File: rtl/cclk_period_sel.sv
// Module: selects the half-period length in system clocks.
// The base length is D+1. Power save multiplies it by 2^(N+1).
// The mode used by a high phase is latched at its rising edge. A low phase
// follows the live bus-idle state.
// Assumes: div and psave_n change only while the block is disabled.
module cclk_period_sel
    import cclk_pkg::*;
#(
    parameter int unsigned DIV_W = CCLK_DIV_W,
    parameter int unsigned PSN_W = CCLK_PSN_W,
    parameter int unsigned CNT_W = cnt_width(DIV_W, PSN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             psave_en,
    input  logic [PSN_W-1:0] psave_n,
    input  logic             bus_busy,
    input  phase_e           phase,
    input  logic             latch_mode,
    input  logic             clr_mode,
    output logic [CNT_W-1:0] half_len
);

    localparam int unsigned NSEL = 1 << PSN_W;

    logic             live_ps;
    logic             mode_q;
    logic             use_ps;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] cand [NSEL];

    // Power save is wanted while enabled and the bus carries nothing.
    always_comb begin
        live_ps = psave_en & ~bus_busy;
    end

    // Remember the mode chosen at a rising edge for the whole high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (clr_mode) begin
            mode_q <= 1'b0;
        end else if (latch_mode) begin
            mode_q <= live_ps;
        end
    end

    // Base half period, D+1, widened to the counter width.
    always_comb begin
        base_len = CNT_W'(div) + CNT_W'(1);
    end

    // One stretched candidate per exponent value: base << (n+1).
    for (genvar g = 0; g < NSEL; g++) begin : g_shift
        assign cand[g] = base_len << (g + 1);
    end

    // High phase uses the latched mode, low phase the live one.
    always_comb begin
        use_ps   = (phase == PH_HIGH) ? mode_q : live_ps;
        half_len = use_ps ? cand[psave_n] : base_len;
    end

endmodule

// File: rtl/cclk_phase_gen.sv
// Module: half-period counter and clock phase register.
// The high phase always runs to its full length. The low phase ends only when
// its count is complete and a rise is allowed; until then the clock waits low.
// Assumes: half_len is at least 1.
module cclk_phase_gen
    import cclk_pkg::*;
#(
    parameter int unsigned CNT_W = cnt_width(CCLK_DIV_W, CCLK_PSN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise_ok,
    input  logic [CNT_W-1:0] half_len,
    output phase_e           phase,
    output logic             rise_go,
    output logic             rise_stb
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             span_done;

    // The phase has used its length once the next count reaches half_len.
    always_comb begin
        cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        span_done = (cnt_inc >= {1'b0, half_len});
        rise_go   = (phase_q == PH_LOW) & span_done & rise_ok;
    end

    // Advance the counter and the phase; stops and restarts happen only low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_LOW;
            cnt_q    <= '0;
            rise_stb <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            if (phase_q == PH_HIGH) begin
                if (span_done) begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_inc[CNT_W-1:0];
                end
            end else if (!en) begin
                cnt_q <= '0;
            end else if (span_done) begin
                if (rise_ok) begin
                    phase_q  <= PH_HIGH;
                    cnt_q    <= '0;
                    rise_stb <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/cclk_gen.sv
// Module: gated card bus clock generator (top).
// It divides clk by 2*(div+1), optionally stretches idle periods by
// 2^(psave_n+1), and holds the clock low during guarded buffer stalls.
// Assumes: div and psave_n change only while en=0 and card_clk=0.
module cclk_gen
    import cclk_pkg::*;
#(
    parameter int unsigned DIV_W = CCLK_DIV_W,
    parameter int unsigned PSN_W = CCLK_PSN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             psave_en,
    input  logic [PSN_W-1:0] psave_n,
    input  logic             rd_guard,
    input  logic             wr_guard,
    input  logic             bus_busy,
    input  logic             rd_active,
    input  logic             wr_active,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             card_clk,
    output logic             rise_stb
);

    localparam int unsigned CNT_W = cnt_width(DIV_W, PSN_W);

    stall_src_t       src [CCLK_NDIR];
    logic             rise_ok;
    logic             rise_go;
    logic             clr_mode;
    phase_e           phase;
    logic [CNT_W-1:0] half_len;

    // Map ports to stall sources: index 0 reads on full, 1 writes on empty.
    always_comb begin
        src[0] = '{guard: rd_guard, active: rd_active, blocked: fifo_full};
        src[1] = '{guard: wr_guard, active: wr_active, blocked: fifo_empty};
    end

    // Clear the latched mode whenever the block sits disabled and low.
    always_comb begin
        clr_mode = ~en & (phase == PH_LOW);
    end

    cclk_stall_ctrl #(
        .NDIR (CCLK_NDIR)
    ) u_stall (
        .en      (en),
        .src     (src),
        .rise_ok (rise_ok)
    );

    cclk_period_sel #(
        .DIV_W (DIV_W),
        .PSN_W (PSN_W),
        .CNT_W (CNT_W)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .div        (div),
        .psave_en   (psave_en),
        .psave_n    (psave_n),
        .bus_busy   (bus_busy),
        .phase      (phase),
        .latch_mode (rise_go),
        .clr_mode   (clr_mode),
        .half_len   (half_len)
    );

    cclk_phase_gen #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rise_ok  (rise_ok),
        .half_len (half_len),
        .phase    (phase),
        .rise_go  (rise_go),
        .rise_stb (rise_stb)
    );

    assign card_clk = (phase == PH_HIGH);

endmodule

// File: rtl/cclk_gen_chk.sv
// Module: property checker for cclk_gen, attached with bind.
// It measures the high-phase length with its own counter.
// Assumes: div changes only while disabled and low.
module cclk_gen_chk
    import cclk_pkg::*;
#(
    parameter int unsigned DIV_W = CCLK_DIV_W,
    parameter int unsigned PSN_W = CCLK_PSN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [DIV_W-1:0] div,
    input logic             rd_guard,
    input logic             wr_guard,
    input logic             rd_active,
    input logic             wr_active,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             card_clk,
    input logic             rise_stb
);

    localparam int unsigned CNT_W = cnt_width(DIV_W, PSN_W);

    logic [CNT_W-1:0] hi_len;

    // Count the cycles card_clk has been seen high in the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !card_clk) begin
            hi_len <= '0;
        end else begin
            hi_len <= hi_len + CNT_W'(1);
        end
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !card_clk) |=> !card_clk);

    a_r3_stb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (card_clk && !$past(card_clk)));

    a_r3_rise_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> rise_stb);

    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk && rd_guard && rd_active && fifo_full) |=> !card_clk);

    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk && wr_guard && wr_active && fifo_empty) |=> !card_clk);

    a_r9_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> (hi_len >= (CNT_W'(div) + CNT_W'(1))));

endmodule

bind cclk_gen cclk_gen_chk #(
    .DIV_W (DIV_W),
    .PSN_W (PSN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div        (div),
    .rd_guard   (rd_guard),
    .wr_guard   (wr_guard),
    .rd_active  (rd_active),
    .wr_active  (wr_active),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .card_clk   (card_clk),
    .rise_stb   (rise_stb)
);

// File: tb/cclk_gen_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus a seeded random mix, compared every cycle
// against a reference model written from the requirements.
module cclk_gen_tb;

    localparam int DIV_W = 8;
    localparam int PSN_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic psave_en = 1'b0;
    logic [PSN_W-1:0] psave_n = '0;
    logic rd_guard = 1'b0, wr_guard = 1'b0, bus_busy = 1'b0;
    logic rd_active = 1'b0, wr_active = 1'b0, fifo_full = 1'b0, fifo_empty = 1'b0;
    logic card_clk, rise_stb;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Reference model state.
    bit m_clk = 0, m_stb = 0, m_mode = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    cclk_gen #(.DIV_W(DIV_W), .PSN_W(PSN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .psave_en(psave_en),
        .psave_n(psave_n), .rd_guard(rd_guard), .wr_guard(wr_guard),
        .bus_busy(bus_busy), .rd_active(rd_active), .wr_active(wr_active),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .card_clk(card_clk), .rise_stb(rise_stb)
    );

    function automatic int half_of(int d, int n, bit ps);
        return ps ? (d + 1) << (n + 1) : d + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_min(string req, int act, int lo);
        n_chk++;
        if (act < lo) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lo);
        end
    endtask

    // Reference model, updated on the same edge as the design.
    always @(posedge clk) begin
        bit live, hs, ok, last;
        int half;
        if (!rst_n) begin
            m_clk = 0; m_stb = 0; m_mode = 0; m_cnt = 0;
        end else begin
            live = psave_en && !bus_busy;
            hs   = m_clk ? m_mode : live;
            half = half_of(int'(div), int'(psave_n), hs);
            ok   = en && !((rd_guard && rd_active && fifo_full) ||
                           (wr_guard && wr_active && fifo_empty));
            last = (m_cnt + 1 >= half);
            m_stb = 0;
            if (m_clk) begin
                if (last) begin m_clk = 0; m_cnt = 0; end
                else m_cnt++;
            end else if (!en) begin
                m_cnt = 0; m_mode = 0;
            end else if (last) begin
                if (ok) begin m_clk = 1; m_cnt = 0; m_mode = live; m_stb = 1; end
            end else begin
                m_cnt++;
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " card_clk"}, int'(card_clk), int'(m_clk));
            chk("R3 rise_stb", int'(rise_stb), int'(m_stb));
        end
    end

    task automatic wait_rise();
        do @(negedge clk); while (!rise_stb);
    endtask

    task automatic period(output int p);
        int k;
        wait_rise();
        wait_rise();
        k = 0;
        do begin @(negedge clk); k++; end while (!rise_stb);
        p = k;
    endtask

    // Disable, wait for a low clock, then load a new configuration.
    task automatic set_cfg(int d, int n);
        en = 0;
        do @(negedge clk); while (card_clk);
        @(negedge clk);
        div = DIV_W'(d);
        psave_n = PSN_W'(n);
        en = 1;
    endtask

    task automatic count_rises(int cycles, output int r);
        r = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rise_stb) r++;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p, r, h, l;
        int dl [4] = '{0, 1, 2, 5};
        void'($urandom(32'd20240611));

        // R1: outputs low in reset and while disabled.
        repeat (3) @(negedge clk);
        chk("R1 reset card_clk", int'(card_clk), 0);
        chk("R1 reset rise_stb", int'(rise_stb), 0);
        rst_n = 1;
        count_rises(20, r);
        chk("R1 disabled rises", r, 0);
        chk("R1 disabled card_clk", int'(card_clk), 0);

        // R2: base period over several dividers.
        cur_req = "R2";
        foreach (dl[i]) begin
            set_cfg(dl[i], 0);
            period(p);
            chk("R2 period", p, 2 * (dl[i] + 1));
            h = 0;
            do begin @(negedge clk); h++; end while (card_clk);
            chk("R2 high length", h, dl[i] + 1);
        end

        // R4: stretched period while idle.
        cur_req = "R4";
        psave_en = 1;
        bus_busy = 0;
        set_cfg(1, 0); period(p); chk("R4 period d1 n0", p, 2 * half_of(1, 0, 1));
        set_cfg(0, 2); period(p); chk("R4 period d0 n2", p, 2 * half_of(0, 2, 1));

        // R5: busy arriving in a stretched high phase.
        cur_req = "R5";
        set_cfg(1, 1);
        wait_rise();
        wait_rise();
        bus_busy = 1;
        h = 1;
        while (1) begin @(negedge clk); if (!card_clk) break; h++; end
        chk("R5 latched high length", h, half_of(1, 1, 1));
        l = 1;
        while (1) begin @(negedge clk); if (card_clk) break; l++; end
        chk("R5 low length after busy", l, 2);
        psave_en = 0;
        bus_busy = 0;

        // R6: read stall on a full buffer.
        cur_req = "R6";
        set_cfg(0, 0);
        rd_guard = 1; rd_active = 1; fifo_full = 1;
        count_rises(40, r);
        chk("R6 rises while held", r, 0);
        fifo_full = 0;
        r = 0;
        do begin @(negedge clk); r++; end while (!rise_stb);
        chk("R6 restart latency", r, 1);
        rd_guard = 0; rd_active = 0;

        // R7: write stall on an empty buffer.
        cur_req = "R7";
        wr_guard = 1; wr_active = 1; fifo_empty = 1;
        count_rises(40, r);
        chk("R7 rises while held", r, 0);
        fifo_empty = 0;
        r = 0;
        do begin @(negedge clk); r++; end while (!rise_stb);
        chk("R7 restart latency", r, 1);

        // R8: flags ignored with guards off.
        cur_req = "R8";
        wr_guard = 0; rd_guard = 0;
        rd_active = 1; wr_active = 1; fifo_full = 1; fifo_empty = 1;
        count_rises(40, r);
        chk_min("R8 rises with guards off", r, 19);
        rd_active = 0; wr_active = 0; fifo_full = 0; fifo_empty = 0;

        // R9: disable mid-pulse, then re-enable.
        cur_req = "R9";
        set_cfg(3, 0);
        wait_rise();
        en = 0;
        h = 1;
        while (1) begin @(negedge clk); if (!card_clk) break; h++; end
        chk("R9 high completes", h, 4);
        count_rises(30, r);
        chk("R9 stays low", r + int'(card_clk), 0);
        en = 1;
        r = 0;
        do begin @(negedge clk); r++; end while (!rise_stb);
        chk("R9 first rise latency", r, 4);

        // Random mix of every input, checked against the model each cycle.
        cur_req = "R5 R6 R7 R9 mix";
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 299) == 0)
                set_cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)));
            else if ($urandom_range(0, 99) == 0)
                en = ~en;
            if ($urandom_range(0, 7) == 0) bus_busy = 1'($urandom);
            if ($urandom_range(0, 31) == 0) psave_en = 1'($urandom);
            if ($urandom_range(0, 15) == 0) begin
                rd_guard = 1'($urandom); wr_guard = 1'($urandom);
                rd_active = 1'($urandom); wr_active = 1'($urandom);
            end
            if ($urandom_range(0, 3) == 0) begin
                fifo_full = 1'($urandom); fifo_empty = 1'($urandom);
            end
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule